// File: doc/BRIEF.md
# Asynchronous Memory Strobe Timer with Ready Extension

This block times one access at a time to an external asynchronous memory that is split into several banks. A requester presents a bank index and a read/write flag while the block shows that it can take a request. The block then holds the matching active-low strobe, read or write, for the number of clock cycles programmed for that bank and direction. When the strobe rises, the block raises a one-cycle completion pulse.

Every bank has four static settings: a read length, a write length, a flag that says whether the external ready line is honoured, and the level at which that line counts as asserted. When ready is honoured, the line is looked at on the last programmed strobe cycle. If it is not asserted there, the strobe is held and the line is looked at again on every following cycle. The access ends on the cycle after the first cycle in which ready is seen asserted. At all other times the ready line is ignored, so it may be left undriven.

Top module: `amem_strobe_seq`

## Requirements
- R1: After reset both strobes are high, `done` is low and `req_ready` is high.
- R2: A request (`req_valid` high at a clock edge) is taken only while `req_ready` is high. `req_ready` stays low from the first strobe-low cycle through the last strobe-low cycle, and requests presented during that time are dropped.
- R3: A read access drives `rd_strobe_n` low, starting in the cycle after acceptance, for the bank's read length, taken from `rd_len_cfg[4*b+3:4*b]` for bank b. `wr_strobe_n` stays high throughout.
- R4: A write access drives `wr_strobe_n` low for the bank's write length, taken from `wr_len_cfg[4*b+3:4*b]`. `rd_strobe_n` stays high throughout.
- R5: A programmed length of 0 gives a strobe one cycle wide. A length of n from 1 to 15 gives a strobe n cycles wide.
- R6: When the bank's bit in `rdy_en_cfg` is 0, `ext_rdy` has no effect, and the strobe width equals the programmed length.
- R7: When ready is honoured and is asserted in the last programmed strobe cycle, the access is not extended.
- R8: When ready is honoured and is not asserted in the last programmed cycle, the strobe stays low. It rises in the cycle after the first cycle in which ready is asserted.
- R9: For bank b, ready counts as asserted when `ext_rdy` equals `rdy_pol_cfg[b]` (1 means active high, 0 means active low).
- R10: `done` is high for exactly one cycle. That cycle is the first cycle with both strobes high after the access, and `req_ready` is high in it.
- R11: While no access is in progress, `ext_rdy` has no effect: the strobes stay high and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request |
| req_bank | input | 2 | Bank index of the request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rd_len_cfg | input | 16 | Read lengths, 4 bits per bank |
| wr_len_cfg | input | 16 | Write lengths, 4 bits per bank |
| rdy_en_cfg | input | 4 | Per-bank flag: honour ext_rdy |
| rdy_pol_cfg | input | 4 | Per-bank asserted level of ext_rdy |
| ext_rdy | input | 1 | External ready, synchronous to clk |
| req_ready | output | 1 | Block is idle and takes a request |
| rd_strobe_n | output | 1 | Active-low read strobe |
| wr_strobe_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong counter load or a wrong length decrement shows up as a strobe that is too short or too long. It is visible on the very access where it happens, when `done` arrives early or late against the strobe count the bench expects. A wrong sequencer state, such as an extension on a bank whose ready flag is off or a polarity mix-up, gives a strobe width that differs from the bench's expected width within that access. A stuck state shows as a missing `done` pulse or a `req_ready` that never returns. A strobe on the wrong direction, or a pulse during idle, is visible in the same cycle it occurs.

// File: rtl/amem_pkg.sv
package amem_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_EXT  = 2'd2
  } seq_state_e;

  // A programmed length of zero still yields a one-cycle strobe.
  function automatic int unsigned eff_len(input int unsigned raw);
    return (raw == 0) ? 1 : raw;
  endfunction

  // Ready is asserted when the line sits at the bank's active level.
  function automatic logic rdy_seen(input logic raw, input logic pol);
    return raw == pol;
  endfunction

endpackage

// File: rtl/amem_len_sel.sv
module amem_len_sel #(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 4,
  parameter int BANK_W    = 2
) (
  input  logic [BANK_W-1:0]          bank_i,
  input  logic                       write_i,
  input  logic [NUM_BANKS*CNT_W-1:0] rd_len_cfg,
  input  logic [NUM_BANKS*CNT_W-1:0] wr_len_cfg,
  output logic [CNT_W-1:0]           len_o
);
  logic [CNT_W-1:0] rd_a [NUM_BANKS];
  logic [CNT_W-1:0] wr_a [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_unpack
    assign rd_a[g] = rd_len_cfg[g*CNT_W +: CNT_W];
    assign wr_a[g] = wr_len_cfg[g*CNT_W +: CNT_W];
  end

  logic [CNT_W-1:0] raw_len;
  always_comb begin
    raw_len = write_i ? wr_a[bank_i] : rd_a[bank_i];
    len_o   = CNT_W'(amem_pkg::eff_len(32'(raw_len)));
  end
endmodule

// File: rtl/amem_rdy_sel.sv
module amem_rdy_sel #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic [BANK_W-1:0]    bank_i,
  input  logic [NUM_BANKS-1:0] rdy_en_cfg,
  input  logic [NUM_BANKS-1:0] rdy_pol_cfg,
  input  logic                 ext_rdy,
  output logic                 en_o,
  output logic                 hit_o
);
  always_comb begin
    en_o  = rdy_en_cfg[bank_i];
    hit_o = amem_pkg::rdy_seen(ext_rdy, rdy_pol_cfg[bank_i]);
  end
endmodule

// File: rtl/amem_countdown.sv
module amem_countdown #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_o <= '0;
    else if (load_i)                cnt_o <= load_val_i;
    else if (step_i && cnt_o != '0) cnt_o <= cnt_o - 1'b1;
  end

  assign last_o = (cnt_o == CNT_W'(1));
endmodule

// File: rtl/amem_strobe_seq.sv
module amem_strobe_seq #(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 4,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [BANK_W-1:0]          req_bank,
  input  logic                       req_write,
  input  logic [NUM_BANKS*CNT_W-1:0] rd_len_cfg,
  input  logic [NUM_BANKS*CNT_W-1:0] wr_len_cfg,
  input  logic [NUM_BANKS-1:0]       rdy_en_cfg,
  input  logic [NUM_BANKS-1:0]       rdy_pol_cfg,
  input  logic                       ext_rdy,
  output logic                       req_ready,
  output logic                       rd_strobe_n,
  output logic                       wr_strobe_n,
  output logic                       done
);
  import amem_pkg::*;

  seq_state_e        state_q;
  logic [BANK_W-1:0] bank_q;
  logic              wr_q;
  logic              done_q;

  // Named internal events, used by the bound checker.
  logic             accept;
  logic             sample_pt;
  logic             ext_phase;
  logic             ext_allowed;
  logic             rdy_hit;
  logic             finish;
  logic [CNT_W-1:0] load_len;
  logic [CNT_W-1:0] cnt;
  logic             cnt_last;

  amem_len_sel #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W), .BANK_W(BANK_W)) u_len (
    .bank_i     (req_bank),
    .write_i    (req_write),
    .rd_len_cfg (rd_len_cfg),
    .wr_len_cfg (wr_len_cfg),
    .len_o      (load_len)
  );

  amem_rdy_sel #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_rdy (
    .bank_i      (bank_q),
    .rdy_en_cfg  (rdy_en_cfg),
    .rdy_pol_cfg (rdy_pol_cfg),
    .ext_rdy     (ext_rdy),
    .en_o        (ext_allowed),
    .hit_o       (rdy_hit)
  );

  amem_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (accept),
    .load_val_i (load_len),
    .step_i     (state_q == ST_RUN),
    .cnt_o      (cnt),
    .last_o     (cnt_last)
  );

  always_comb begin
    accept    = req_valid && (state_q == ST_IDLE);
    sample_pt = (state_q == ST_RUN) && cnt_last;
    ext_phase = (state_q == ST_EXT);
    finish    = (sample_pt && (!ext_allowed || rdy_hit)) || (ext_phase && rdy_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bank_q  <= '0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_RUN;
          bank_q  <= req_bank;
          wr_q    <= req_write;
        end
        ST_RUN: if (finish)         state_q <= ST_IDLE;
                else if (sample_pt) state_q <= ST_EXT;
        ST_EXT: if (finish)         state_q <= ST_IDLE;
        default:                    state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign rd_strobe_n = !((state_q != ST_IDLE) && !wr_q);
  assign wr_strobe_n = !((state_q != ST_IDLE) && wr_q);
  assign done        = done_q;
endmodule

// File: rtl/amem_strobe_chk.sv
module amem_strobe_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rd_strobe_n,
  input logic wr_strobe_n,
  input logic done,
  input logic ext_phase,
  input logic ext_allowed
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_strobe_n && !wr_strobe_n)); // R3

  AST_START_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_strobe_n) || $fell(wr_strobe_n)) |-> $past(req_valid && req_ready)); // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DONE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_strobe_n && wr_strobe_n && req_ready &&
              ($past(!rd_strobe_n) || $past(!wr_strobe_n)))); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (rd_strobe_n && wr_strobe_n)); // R11

  AST_EXT_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ext_phase |-> ext_allowed); // R6
endmodule

bind amem_strobe_seq amem_strobe_chk u_chk (.*);

// File: tb/tb_amem_strobe_seq.sv
module tb_amem_strobe_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_bank = '0;
  logic        req_write = 1'b0;
  logic [15:0] rd_len_cfg, wr_len_cfg;
  logic [3:0]  rdy_en_cfg, rdy_pol_cfg;
  logic        ext_rdy = 1'b0;
  logic        req_ready, rd_strobe_n, wr_strobe_n, done;

  logic [3:0] rlen [4];
  logic [3:0] wlen [4];
  logic [3:0] en_b, pol_b;
  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      rd_len_cfg[i*4 +: 4] = rlen[i];
      wr_len_cfg[i*4 +: 4] = wlen[i];
    end
    rdy_en_cfg  = en_b;
    rdy_pol_cfg = pol_b;
  end

  amem_strobe_seq dut (.*);

  function automatic int exp_width(input int len, input bit en, input int rdy_at);
    int n;
    n = (len == 0) ? 1 : len;
    if (en && rdy_at > n) return rdy_at;
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // rdy_at: ready is driven asserted from strobe cycle rdy_at onward.
  task automatic access(input int b, input bit w, input int rdy_at, input bit busy_req,
                        input string req);
    int low, other, guard, exp;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_bank = 2'(b); req_write = w;
    @(negedge clk);
    if (busy_req) begin req_write = ~w; req_bank = 2'(b + 1); end
    else req_valid = 1'b0;
    low = 0; other = 0; guard = 0;
    while (!done && guard < 100) begin
      if ((w ? wr_strobe_n : rd_strobe_n) == 1'b0) low++;
      if ((w ? rd_strobe_n : wr_strobe_n) == 1'b0) other++;
      if (en_b[b]) ext_rdy = (low >= rdy_at) ? pol_b[b] : ~pol_b[b];
      else         ext_rdy = 1'($urandom);
      @(negedge clk);
      guard++;
    end
    req_valid = 1'b0;
    exp = exp_width(w ? int'(wlen[b]) : int'(rlen[b]), en_b[b], rdy_at);
    check(low == exp, req, low, exp);
    check(other == 0, "R3/R4 other strobe", other, 0);
    check(rd_strobe_n && wr_strobe_n && req_ready && done, "R10 done at rise",
          int'(done), 1);
    @(negedge clk);
    check(!done, "R10 single pulse", int'(done), 0);
  endtask

  initial begin
    int seed = 32'd20240611;
    void'($urandom(seed));
    for (int i = 0; i < 4; i++) begin rlen[i] = 4'(i + 2); wlen[i] = 4'(i + 5); end
    en_b = 4'b0000; pol_b = 4'b1111;
    repeat (3) @(negedge clk);
    check(rd_strobe_n && wr_strobe_n && !done && req_ready, "R1 in reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_strobe_n && wr_strobe_n && !done && req_ready, "R1 after reset", 0, 0);

    // Every bank and direction, ready ignored.
    for (int b = 0; b < 4; b++) begin
      access(b, 1'b0, 0, 0, "R3 read width");
      access(b, 1'b1, 0, 0, "R4 write width");
    end
    // R5: zero length.
    rlen[1] = 4'd0; wlen[2] = 4'd0;
    access(1, 1'b0, 0, 0, "R5 zero read");
    access(2, 1'b1, 0, 0, "R5 zero write");
    rlen[3] = 4'd15;
    access(3, 1'b0, 0, 0, "R5 max read");
    // R6: disabled bank with noise on ready.
    access(0, 1'b1, 12, 0, "R6 disabled ignores ready");
    // R7 / R8 / R9
    en_b = 4'b1111; pol_b = 4'b1111;
    rlen[0] = 4'd4;
    access(0, 1'b0, 4, 0, "R7 ready at sample point");
    access(0, 1'b0, 1, 0, "R7 ready early");
    access(0, 1'b0, 9, 0, "R8 extension");
    access(0, 1'b0, 5, 0, "R8 one-cycle extension");
    pol_b = 4'b1011;
    wlen[2] = 4'd3;
    access(2, 1'b1, 8, 0, "R9 active-low extension");
    access(2, 1'b1, 3, 0, "R9 active-low no extension");
    // R2: request held during access.
    access(3, 1'b1, 11, 1, "R2 busy request dropped");
    // R11: ready toggling while idle.
    begin
      int quiet = 1;
      for (int k = 0; k < 20; k++) begin
        ext_rdy = ~ext_rdy;
        @(negedge clk);
        if (!(rd_strobe_n && wr_strobe_n && !done && req_ready)) quiet = 0;
      end
      check(quiet == 1, "R11 idle ignores ready", quiet, 1);
    end
    // Random mix.
    for (int t = 0; t < 60; t++) begin
      for (int i = 0; i < 4; i++) begin
        rlen[i] = 4'($urandom); wlen[i] = 4'($urandom);
      end
      en_b = 4'($urandom); pol_b = 4'($urandom);
      access(int'($urandom % 4), 1'($urandom), int'($urandom % 20), 1'($urandom),
             "R8 random mix");
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule